// File: doc/BRIEF.md
# Bit-Addressed Move-Only Processor

This block is a small processor that has no programmer-visible registers and only one operation. All of its architectural state sits in a memory of 2^W individually addressed bits. The unit of data is W bits, which is also the width of an address. A unit may start at any bit address, and a unit that runs past the top of memory continues at bit zero.

Each instruction is a pair of units. The first unit gives a source bit address and the second gives a destination bit address. Executing the instruction copies W bits from the source to the destination. The program counter is the unit at bit zero and the previous program counter is the unit at bit W. A jump is therefore an ordinary move whose destination is bit zero, and a shift is a move to a destination displaced by the shift distance.

A test port loads the memory while the core is held in reset and reads it back at any time. The core stops by itself on a move that sends execution back to the instruction it is executing. It then raises `halted`.

Top module: `mvp_move_core`

## Requirements
- R1: The memory holds 2^W bits, with W = `ADDR_W`. Reading a unit at bit address a on `dbg_rdata` returns memory bit (a+k) mod 2^W in bit k, so the least significant bit comes from the lowest address.
- R2: While `rst_n` is low, and for two clock cycles after it rises, `halted` is low and bits 0 to 2W-1 (the program counter and the previous program counter) are held at zero. This takes priority over any load through the test port. `halted` falls as soon as `rst_n` falls.
- R3: A test-port write stores `dbg_wdata` as a unit at `dbg_addr`, wrapping past the top of memory. It takes effect only while the core is held in reset. When the core is running or halted, the write is ignored.
- R4: After reset, execution starts at program counter 0. An instruction at program counter p takes its source address from the unit at p and its destination address from the unit at p+W (mod 2^W). The start-up instruction at address 0 therefore reads source 0 and destination W.
- R5: A move copies exactly W bits from the source unit to the destination unit, for any alignment and with wrap-around. Every bit outside the destination unit and outside the two state units keeps its value.
- R6: Before the data is copied, the previous program counter receives the instruction's address p, and the program counter receives p+2W (mod 2^W).
- R7: A move whose destination is bit address 0 sets the next instruction address to the moved value. The data write overrides the increment.
- R8: The source unit is read after the R6 updates. A source that overlaps bits 0 to 2W-1 therefore sees the updated state values.
- R9: A move to destination 0 whose value equals the executing instruction's own address halts the core. `halted` then stays high until reset and memory is not modified again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the core leaves reset synchronously |
| dbg_we | input | 1 | Test-port unit write strobe (only honoured while in reset) |
| dbg_addr | input | ADDR_W | Test-port bit address, for both read and write |
| dbg_wdata | input | ADDR_W | Test-port unit to write |
| dbg_rdata | output | ADDR_W | Unit that starts at `dbg_addr` |
| halted | output | 1 | High once a self-loop move has executed |

## Verification
The main test sweeps every source bit address against three destination offsets in turn, over a pseudo-random memory pattern, and compares the whole memory with an arithmetic model after each halt. Sources below 2W separate a core that reads the source after updating the state units from one that reads it before. Sources near the top of memory expose faulty wrap-around, and odd destinations expose alignment faults. Separate programs exercise a jump that skips a trap instruction, loads that straddle the top of memory during reset, and writes attempted after halting. Each of these tells apart the increment-versus-jump ordering, the clear priority and the reset-only load window.

// File: rtl/mvp_pkg.sv
`timescale 1ns/1ps
package mvp_pkg;

  // Sequencer phases for one move: fetch three units, update state, copy.
  typedef enum logic [3:0] {
    ST_CLEAR,
    ST_GET_PC,
    ST_GET_SRC,
    ST_GET_DST,
    ST_SAVE_PREV,
    ST_ADVANCE,
    ST_LOAD,
    ST_STORE,
    ST_HALT
  } seq_state_e;

endpackage

// File: rtl/mvp_rst_sync.sv
`timescale 1ns/1ps
module mvp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  assign sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign run = sync_q[STAGES-1];

endmodule

// File: rtl/mvp_bitmem.sv
`timescale 1ns/1ps
module mvp_bitmem #(
  parameter int ADDR_W   = 8,
  parameter int RD_PORTS = 2
) (
  input  logic                               clk,
  input  logic                               clr_state,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [ADDR_W-1:0]                  wr_data,
  input  logic [RD_PORTS-1:0][ADDR_W-1:0]    rd_addr,
  output logic [RD_PORTS-1:0][ADDR_W-1:0]    rd_data
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int STATE_BITS = 2 * ADDR_W;
  localparam int IDX_W      = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam logic [ADDR_W:0] UNIT_LEN = (ADDR_W+1)'(ADDR_W);

  logic bits_q [DEPTH];

  // Unit read ports: bit k of a port comes from (addr + k) mod DEPTH.
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [ADDR_W-1:0] word;
    always_comb begin
      logic [ADDR_W-1:0] a;
      a = '0;
      for (int k = 0; k < ADDR_W; k++) begin
        a       = rd_addr[p] + ADDR_W'(k);
        word[k] = bits_q[a];
      end
    end
    assign rd_data[p] = word;
  end

  // Per-bit write decode: a bit belongs to the unit when its distance
  // above the write address (mod DEPTH) is below the unit length.
  for (genvar i = 0; i < DEPTH; i++) begin : g_bit
    logic [ADDR_W-1:0] off;
    logic              hit;
    logic              bit_en;
    logic              bit_d;

    assign off = ADDR_W'(i) - wr_addr;
    assign hit = wr_en && ({1'b0, off} < UNIT_LEN);

    if (i < STATE_BITS) begin : g_state
      assign bit_en = clr_state || hit;
      assign bit_d  = clr_state ? 1'b0 : wr_data[off[IDX_W-1:0]];
    end else begin : g_plain
      assign bit_en = hit;
      assign bit_d  = wr_data[off[IDX_W-1:0]];
    end

    always_ff @(posedge clk) begin
      if (bit_en) begin
        bits_q[i] <= bit_d;
      end
    end
  end

endmodule

// File: rtl/mvp_move_seq.sv
`timescale 1ns/1ps
module mvp_move_seq
  import mvp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] wr_data,
  output logic              clr_state,
  output logic              halted
);

  localparam logic [ADDR_W-1:0] PC_LOC    = '0;
  localparam logic [ADDR_W-1:0] PREV_LOC  = ADDR_W'(ADDR_W);
  localparam logic [ADDR_W-1:0] INSTR_LEN = ADDR_W'(2 * ADDR_W);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pc_q, src_q, dst_q, data_q;
  logic              pc_en, src_en, dst_en, data_en;
  logic              self_loop;

  assign self_loop = (dst_q == PC_LOC) && (data_q == pc_q);

  always_comb begin
    state_d   = state_q;
    rd_addr   = '0;
    wr_en     = 1'b0;
    wr_addr   = '0;
    wr_data   = '0;
    clr_state = 1'b0;
    pc_en     = 1'b0;
    src_en    = 1'b0;
    dst_en    = 1'b0;
    data_en   = 1'b0;
    case (state_q)
      ST_CLEAR: begin
        clr_state = 1'b1;
        if (run) state_d = ST_GET_PC;
      end
      ST_GET_PC: begin
        rd_addr = PC_LOC;
        pc_en   = 1'b1;
        state_d = ST_GET_SRC;
      end
      ST_GET_SRC: begin
        rd_addr = pc_q;
        src_en  = 1'b1;
        state_d = ST_GET_DST;
      end
      ST_GET_DST: begin
        rd_addr = pc_q + PREV_LOC;
        dst_en  = 1'b1;
        state_d = ST_SAVE_PREV;
      end
      ST_SAVE_PREV: begin
        wr_en   = 1'b1;
        wr_addr = PREV_LOC;
        wr_data = pc_q;
        state_d = ST_ADVANCE;
      end
      ST_ADVANCE: begin
        wr_en   = 1'b1;
        wr_addr = PC_LOC;
        wr_data = pc_q + INSTR_LEN;
        state_d = ST_LOAD;
      end
      ST_LOAD: begin
        rd_addr = src_q;
        data_en = 1'b1;
        state_d = ST_STORE;
      end
      ST_STORE: begin
        wr_en   = 1'b1;
        wr_addr = dst_q;
        wr_data = data_q;
        state_d = self_loop ? ST_HALT : ST_GET_PC;
      end
      ST_HALT: begin
        state_d = ST_HALT;
      end
      default: begin
        state_d = ST_CLEAR;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CLEAR;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pc_en)   pc_q   <= rd_data;
    if (src_en)  src_q  <= rd_data;
    if (dst_en)  dst_q  <= rd_data;
    if (data_en) data_q <= rd_data;
  end

  assign halted = (state_q == ST_HALT);

endmodule

// File: rtl/mvp_move_core.sv
`timescale 1ns/1ps
module mvp_move_core #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [ADDR_W-1:0] dbg_wdata,
  output logic [ADDR_W-1:0] dbg_rdata,
  output logic              halted
);

  localparam int MEM_PORTS = 2;
  localparam int SYNC_LEN  = 2;

  logic                             run;
  logic [ADDR_W-1:0]                seq_rd_addr;
  logic                             seq_we;
  logic [ADDR_W-1:0]                seq_wr_addr;
  logic [ADDR_W-1:0]                seq_wr_data;
  logic                             seq_clr;
  logic                             dbg_load;
  logic                             mem_we;
  logic [ADDR_W-1:0]                mem_wr_addr;
  logic [ADDR_W-1:0]                mem_wr_data;
  logic [MEM_PORTS-1:0][ADDR_W-1:0] mem_rd_addr;
  logic [MEM_PORTS-1:0][ADDR_W-1:0] mem_rd_data;

  mvp_rst_sync #(.STAGES(SYNC_LEN)) i_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  mvp_move_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .rd_addr   (seq_rd_addr),
    .rd_data   (mem_rd_data[0]),
    .wr_en     (seq_we),
    .wr_addr   (seq_wr_addr),
    .wr_data   (seq_wr_data),
    .clr_state (seq_clr),
    .halted    (halted)
  );

  // Test-port loads share the single write port and are only let through
  // while the core is held in reset.
  assign dbg_load    = dbg_we && !run;
  assign mem_we      = seq_we || dbg_load;
  assign mem_wr_addr = seq_we ? seq_wr_addr : dbg_addr;
  assign mem_wr_data = seq_we ? seq_wr_data : dbg_wdata;

  assign mem_rd_addr[0] = seq_rd_addr;
  assign mem_rd_addr[1] = dbg_addr;
  assign dbg_rdata      = mem_rd_data[1];

  mvp_bitmem #(.ADDR_W(ADDR_W), .RD_PORTS(MEM_PORTS)) i_mem (
    .clk       (clk),
    .clr_state (seq_clr),
    .wr_en     (mem_we),
    .wr_addr   (mem_wr_addr),
    .wr_data   (mem_wr_data),
    .rd_addr   (mem_rd_addr),
    .rd_data   (mem_rd_data)
  );

endmodule

// File: rtl/mvp_move_core_chk.sv
`timescale 1ns/1ps
module mvp_move_core_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              halted,
  input logic              seq_we,
  input logic [ADDR_W-1:0] seq_wr_addr,
  input logic [ADDR_W-1:0] seq_wr_data,
  input logic              dbg_we,
  input logic              mem_we
);

  localparam logic [ADDR_W-1:0] PREV_LOC = ADDR_W'(ADDR_W);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(2 * ADDR_W);

  // R2: no execution and no halt indication while held in reset
  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!halted && !seq_we));

  // R3: once running, test-port strobes never reach the memory
  assert_dbg_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dbg_we && !seq_we) |-> !mem_we);

  // R6: the only back-to-back writes are previous-PC save then PC advance
  assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_we && $past(seq_we)) |->
      ($past(seq_wr_addr) == PREV_LOC && seq_wr_addr == '0 &&
       seq_wr_data == $past(seq_wr_data) + STEP));

  // R9: halt comes right after a write to the program counter
  assert_halt_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(seq_we && seq_wr_addr == '0));

  // R9: halt is sticky
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R9: no memory writes of any kind once halted
  assert_halt_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

endmodule

bind mvp_move_core mvp_move_core_chk #(.ADDR_W(ADDR_W)) i_move_core_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .halted      (halted),
  .seq_we      (seq_we),
  .seq_wr_addr (seq_wr_addr),
  .seq_wr_data (seq_wr_data),
  .dbg_we      (dbg_we),
  .mem_we      (mem_we)
);

// File: tb/test_mvp_move_core.sv
`timescale 1ns/1ps
module test_mvp_move_core;

  localparam int AW     = 8;
  localparam int MS     = 1 << AW;
  localparam int NUNITS = MS / AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dbg_we;
  logic [AW-1:0] dbg_addr;
  logic [AW-1:0] dbg_wdata;
  logic [AW-1:0] dbg_rdata;
  logic          halted;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [MS-1:0] img;
  logic [MS-1:0] exp_mem;

  always #2.5 clk = ~clk;

  mvp_move_core #(.ADDR_W(AW)) i_mvp_move_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_we    (dbg_we),
    .dbg_addr  (dbg_addr),
    .dbg_wdata (dbg_wdata),
    .dbg_rdata (dbg_rdata),
    .halted    (halted)
  );

  function automatic logic [AW-1:0] get_unit(input logic [MS-1:0] m, input int a);
    logic [AW-1:0] r;
    for (int k = 0; k < AW; k++) r[k] = m[(a + k) % MS];
    return r;
  endfunction

  function automatic logic [MS-1:0] with_unit(input logic [MS-1:0] m, input int a,
                                              input logic [AW-1:0] v);
    for (int k = 0; k < AW; k++) m[(a + k) % MS] = v[k];
    return m;
  endfunction

  // Model of the requirements: state units cleared, then moves until a self-loop.
  function automatic logic [MS-1:0] model_run(input logic [MS-1:0] m);
    int pc, s, d;
    logic [AW-1:0] v;
    for (int k = 0; k < 2 * AW; k++) m[k] = 1'b0;
    for (int step = 0; step < 64; step++) begin
      pc = int'(get_unit(m, 0));
      s  = int'(get_unit(m, pc));
      d  = int'(get_unit(m, (pc + AW) % MS));
      m  = with_unit(m, AW, AW'(pc));
      m  = with_unit(m, 0, AW'((pc + 2 * AW) % MS));
      v  = get_unit(m, s);
      m  = with_unit(m, d, v);
      if (d == 0 && int'(v) == pc) break;
    end
    return m;
  endfunction

  function automatic logic [MS-1:0] pattern(input int seed);
    logic [MS-1:0] m;
    logic [31:0] h;
    for (int i = 0; i < MS; i++) begin
      h = (32'(i) * 32'h9E3779B1) ^ (32'(seed) * 32'h7F4A7C15);
      h = h ^ (h >> 15);
      m[i] = h[3];
    end
    return m;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic read_unit(input int a, output logic [AW-1:0] v);
    dbg_addr = AW'(a);
    #1;
    v = dbg_rdata;
  endtask

  task automatic load_image(input logic [MS-1:0] m);
    for (int u = 0; u < NUNITS; u++) begin
      @(negedge clk);
      dbg_we    = 1'b1;
      dbg_addr  = AW'(u * AW);
      dbg_wdata = get_unit(m, u * AW);
    end
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic run_image(input logic [MS-1:0] m, input string req);
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    load_image(m);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!halted) chk(req, "halt reached", 32'(halted), 32'd1);
  endtask

  task automatic compare_mem(input logic [MS-1:0] m, input string req);
    logic [AW-1:0] v;
    int bad;
    bad = 0;
    for (int u = 0; u < NUNITS; u++) begin
      read_unit(u * AW, v);
      if (v !== get_unit(m, u * AW)) begin
        if (bad == 0) chk(req, $sformatf("unit @%0d", u * AW), 32'(v), 32'(get_unit(m, u * AW)));
        bad++;
      end
    end
    if (bad == 0) checks++;
  endtask

  initial begin
    #(190000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] v;
    logic [MS-1:0] snap;
    int dsts [3];
    string tag;
    dsts[0] = 64; dsts[1] = 97; dsts[2] = 203;
    rst_n = 1'b0; dbg_we = 1'b0; dbg_addr = '0; dbg_wdata = '0;

    // R2: reset state
    repeat (3) @(negedge clk);
    chk("R2", "halted in reset", 32'(halted), 32'd0);
    read_unit(0, v);  chk("R2", "PC in reset", 32'(v), 32'd0);
    read_unit(AW, v); chk("R2", "prev PC in reset", 32'(v), 32'd0);

    // R3 wrap write, R2 clear priority, R1 unaligned read
    @(negedge clk); dbg_we = 1'b1; dbg_addr = 8'd252; dbg_wdata = 8'hA5;
    @(negedge clk); dbg_addr = 8'd96;  dbg_wdata = 8'hFF;
    @(negedge clk); dbg_addr = 8'd100; dbg_wdata = 8'h96;
    @(negedge clk); dbg_we = 1'b0;
    read_unit(252, v); chk("R2", "wrap write into cleared state", 32'(v), 32'h05);
    read_unit(100, v); chk("R3", "load unaligned", 32'(v), 32'h96);
    read_unit(98, v);  chk("R1", "read straddling units", 32'(v), 32'h5B);

    // R4 R5 R6 R8 R1: sweep every source against three destinations
    for (int s = 0; s < MS; s++) begin
      for (int j = 0; j < 3; j++) begin
        img = pattern(s * 3 + j);
        img = with_unit(img, 16, AW'(s));
        img = with_unit(img, 24, AW'(dsts[j]));
        img = with_unit(img, 32, 8'd48);
        img = with_unit(img, 40, 8'd0);
        img = with_unit(img, 48, 8'd32);
        exp_mem = model_run(img);
        tag = (s < 2 * AW) ? "R8" : ((s > MS - AW) ? "R1" : "R5");
        run_image(img, tag);
        compare_mem(exp_mem, tag);
      end
    end

    // R7: jump over a trap instruction, then halt
    img = pattern(999);
    img = with_unit(img, 16, 8'd48);   img = with_unit(img, 24, 8'd0);
    img = with_unit(img, 32, 8'd56);   img = with_unit(img, 40, 8'd200);
    img = with_unit(img, 48, 8'd80);   img = with_unit(img, 56, 8'hC3);
    img = with_unit(img, 64, 8'h5A);   img = with_unit(img, 200, 8'h11);
    img = with_unit(img, 80, 8'd64);   img = with_unit(img, 88, 8'd120);
    img = with_unit(img, 96, 8'd112);  img = with_unit(img, 104, 8'd0);
    img = with_unit(img, 112, 8'd96);
    exp_mem = model_run(img);
    run_image(img, "R7");
    read_unit(120, v); chk("R7", "jump target executed", 32'(v), 32'h5A);
    read_unit(200, v); chk("R7", "trap skipped", 32'(v), 32'h11);
    read_unit(0, v);   chk("R6", "PC at halt", 32'(v), 32'd96);
    read_unit(AW, v);  chk("R6", "prev PC at halt", 32'(v), 32'd96);
    compare_mem(exp_mem, "R7");

    // R9 halt stays, R3 write ignored when halted
    repeat (30) @(negedge clk);
    chk("R9", "halt sticky", 32'(halted), 32'd1);
    read_unit(160, v);
    snap = exp_mem;
    @(negedge clk); dbg_we = 1'b1; dbg_addr = 8'd160; dbg_wdata = ~v;
    @(negedge clk); dbg_we = 1'b0;
    read_unit(160, v); chk("R3", "write ignored after halt", 32'(v), 32'(get_unit(snap, 160)));
    compare_mem(snap, "R9");

    // R2: reset again clears state and halt
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R2", "halted drops on reset", 32'(halted), 32'd0);
    repeat (2) @(negedge clk);
    read_unit(0, v);  chk("R2", "PC cleared", 32'(v), 32'd0);
    read_unit(AW, v); chk("R2", "prev PC cleared", 32'(v), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule